// File: doc/BRIEF.md
# Fixed-Priority Trap Controller

This block collects error reports from the hardware checkers around a processor core (arithmetic fault, bad address, stack limit violation, clock source failure) and turns them into trap dispatches. Every report latches into a sticky pending flag. The highest-level flag that has not yet been dispatched is handed to the core as a one-cycle dispatch strobe. The strobe comes with a 3-bit vector index, the 4-bit trap level and a hard/soft class bit. Traps live in a band of levels 8 to 15 that sits above every maskable priority. The core's priority level setting therefore never holds a trap back. A level-7 setting, which shuts out all maskable interrupts, still lets traps through.

On dispatch the controller raises the effective priority level to the trap's own level, so bit 3 is always set while a trap runs. It saves the level that was in force before the dispatch on a small last-in first-out shadow store. Each return-from-trap pulse pops one entry and restores it. Traps nest: once the core confirms that vectoring is complete, another pending trap may be dispatched on top of the one in service, whatever their relative levels.

Software reads the pending flags to find every fault raised at once and clears them by writing ones. A flag that has been dispatched is not dispatched again until software clears it.

Top module: `fixed_trap_arb`

## Requirements
- R1: After a synchronous reset the pending flags read 0, the dispatch strobe is low, `in_trap` is low and `ipl_out` is 0.
- R2: A request pulse sets its pending flag, visible one clock after the request cycle. The flag stays set until cleared by software. A request in the same cycle as a clear of that bit leaves the flag set.
- R3: A clear write (`clr_we` high) clears exactly the pending bits written as 1 and leaves all others unchanged. Pending bit positions are: bit 3 arithmetic (level 11), bit 4 address (level 12), bit 5 stack (level 13), bit 6 clock failure (level 14). Bits 0, 1, 2 and 7 are reserved and always read 0.
- R4: Among pending flags not yet dispatched, the one with the highest level is dispatched. `take_idx` equals the level minus 8 and `take_lvl` equals the level.
- R5: The dispatch strobe is high for exactly one cycle, one cycle after the pending flag first reads set. After a dispatch, no further strobe occurs until `vec_done` has been seen.
- R6: `hard_cls` is 1 when the dispatched level is 12 or higher and 0 for levels 8 to 11.
- R7: Outside any trap, `ipl_out` follows `cur_ipl` with one cycle of delay. Traps are dispatched whatever the value of `cur_ipl`, including 7. From the dispatch on, `ipl_out` equals the dispatched level.
- R8: Traps nest. After `vec_done`, a further pending trap is dispatched during service of an earlier one. Each `trap_ret` restores the priority level saved at the matching dispatch, in last-in first-out order. `in_trap` falls when the outermost trap returns.
- R9: A dispatched trap whose pending flag is still set is not dispatched again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| math_err | input | 1 | Arithmetic fault request pulse (level 11) |
| addr_err | input | 1 | Address fault request pulse (level 12) |
| stack_err | input | 1 | Stack fault request pulse (level 13) |
| osc_fail | input | 1 | Clock source failure request pulse (level 14) |
| cur_ipl | input | 4 | Priority level currently set in the core |
| vec_done | input | 1 | Core has finished vectoring to the dispatched trap |
| trap_ret | input | 1 | Return-from-trap pulse |
| clr_we | input | 1 | Software clear write enable |
| clr_mask | input | 8 | Write-one-to-clear mask for the pending flags |
| take_stb | output | 1 | One-cycle trap dispatch strobe |
| take_idx | output | 3 | Vector index of the dispatched trap (level minus 8) |
| take_lvl | output | 4 | Level of the dispatched trap |
| hard_cls | output | 1 | Dispatched trap is of the hard class |
| ipl_out | output | 4 | Effective priority level for the core |
| in_trap | output | 1 | At least one trap is in service |
| pend_flags | output | 8 | Sticky pending flags |

## Verification
Suppose the dispatched marker for a flag is wrong. If it is stuck clear, the strobe fires again for the same index two cycles after `vec_done`. If it is stuck set, the strobe never fires for a freshly raised fault. A shadow store pointer that slips shows up as a wrong `ipl_out` in the cycle after a `trap_ret`, or as `in_trap` falling one return too early. The bench exercises both through a two-deep nesting sequence. A broken encoder ordering shows as a wrong `take_idx` on the very first strobe after several faults arrive together, which the vector table covers with several combinations of simultaneous sources.

// File: rtl/fixed_trap_arb_pkg.sv
package fixed_trap_arb_pkg;

  // level of pending bit 0; bit i stands for level LVL_BASE + i
  localparam int LVL_BASE = 8;

  // pending bit positions of the live sources (level minus LVL_BASE)
  localparam int IDX_MATH  = 3;
  localparam int IDX_ADDR  = 4;
  localparam int IDX_STACK = 5;
  localparam int IDX_OSC   = 6;

  // first index of the hard class (level 12)
  localparam int HARD_IDX_MIN = 4;

  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_VECT = 1'b1
  } arb_state_e;

endpackage

// File: rtl/trap_prio_enc.sv
module trap_prio_enc #(
  parameter int N     = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  // higher index means higher level, so the last hit in ascending order wins
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/trap_pend_bank.sv
module trap_pend_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] take_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] cand_o
);

  logic [N-1:0] pend_q;
  logic [N-1:0] done_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    // flag: a new request outranks a clear in the same cycle
    always_ff @(posedge clk) begin
      if (rst)
        pend_q[g] <= 1'b0;
      else if (set_i[g])
        pend_q[g] <= 1'b1;
      else if (clr_i[g])
        pend_q[g] <= 1'b0;
    end

    // dispatched marker: forgotten when software clears the flag
    always_ff @(posedge clk) begin
      if (rst)
        done_q[g] <= 1'b0;
      else if (clr_i[g])
        done_q[g] <= 1'b0;
      else if (take_i[g])
        done_q[g] <= 1'b1;
    end

    assign cand_o[g] = pend_q[g] & ~done_q[g];
  end

  assign pend_o = pend_q;

endmodule

// File: rtl/trap_ipl_stack.sv
module trap_ipl_stack #(
  parameter int DEPTH = 8,
  parameter int W     = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     top,
  output logic [CNT_W-1:0] count,
  output logic             full
);

  // storage without reset so it maps onto distributed memory
  logic [W-1:0]     mem [DEPTH];
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (push && !full)
      mem[PTR_W'(cnt_q)] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (push && !full)
      cnt_q <= cnt_q + 1'b1;
    else if (pop && cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign top   = mem[PTR_W'(cnt_q - 1'b1)];
  assign count = cnt_q;
  assign full  = (cnt_q == CNT_W'(DEPTH));

endmodule

// File: rtl/fixed_trap_arb.sv
module fixed_trap_arb
  import fixed_trap_arb_pkg::*;
#(
  parameter int NLVL  = 8,
  parameter int IPL_W = 4,
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(NLVL),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             math_err,
  input  logic             addr_err,
  input  logic             stack_err,
  input  logic             osc_fail,
  input  logic [IPL_W-1:0] cur_ipl,
  input  logic             vec_done,
  input  logic             trap_ret,
  input  logic             clr_we,
  input  logic [NLVL-1:0]  clr_mask,
  output logic             take_stb,
  output logic [IDX_W-1:0] take_idx,
  output logic [IPL_W-1:0] take_lvl,
  output logic             hard_cls,
  output logic [IPL_W-1:0] ipl_out,
  output logic             in_trap,
  output logic [NLVL-1:0]  pend_flags
);

  // ---------------- request vector (reserved levels held low) -----------
  logic [NLVL-1:0] req_vec;
  logic [NLVL-1:0] clr_vec;

  always_comb begin
    req_vec            = '0;
    req_vec[IDX_MATH]  = math_err;
    req_vec[IDX_ADDR]  = addr_err;
    req_vec[IDX_STACK] = stack_err;
    req_vec[IDX_OSC]   = osc_fail;
  end

  assign clr_vec = clr_we ? clr_mask : '0;

  // ---------------- pending flags and dispatched markers ----------------
  logic [NLVL-1:0] cand;
  logic [NLVL-1:0] take_vec;

  trap_pend_bank #(.N(NLVL)) u_pend (
    .clk    (clk),
    .rst    (rst),
    .set_i  (req_vec),
    .clr_i  (clr_vec),
    .take_i (take_vec),
    .pend_o (pend_flags),
    .cand_o (cand)
  );

  // ---------------- selection ----------------
  logic             sel_any;
  logic [IDX_W-1:0] sel_idx;

  trap_prio_enc #(.N(NLVL)) u_enc (
    .req (cand),
    .any (sel_any),
    .idx (sel_idx)
  );

  // ---------------- shadow level store ----------------
  logic [IPL_W-1:0] saved_top;
  logic [CNT_W-1:0] depth;
  logic             stk_full;
  logic             do_take;
  logic             do_ret;
  logic [IPL_W-1:0] pre_ipl;
  logic [IPL_W-1:0] sel_lvl;

  arb_state_e state_q;

  // a return in the same cycle defers the dispatch by one clock
  assign do_take  = (state_q == ARB_IDLE) && sel_any && !trap_ret && !stk_full;
  assign do_ret   = trap_ret && (depth != '0);
  assign take_vec = do_take ? (NLVL'(1) << sel_idx) : '0;
  assign sel_lvl  = IPL_W'(LVL_BASE) + IPL_W'(sel_idx);
  assign pre_ipl  = (depth == '0) ? cur_ipl : ipl_out;

  trap_ipl_stack #(.DEPTH(DEPTH), .W(IPL_W)) u_stk (
    .clk       (clk),
    .rst       (rst),
    .push      (do_take),
    .push_data (pre_ipl),
    .pop       (do_ret),
    .top       (saved_top),
    .count     (depth),
    .full      (stk_full)
  );

  // ---------------- dispatch handshake ----------------
  always_ff @(posedge clk) begin
    if (rst)
      state_q <= ARB_IDLE;
    else if (do_take)
      state_q <= ARB_VECT;
    else if (state_q == ARB_VECT && vec_done)
      state_q <= ARB_IDLE;
  end

  // ---------------- registered dispatch outputs ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      take_stb <= 1'b0;
      take_idx <= '0;
      take_lvl <= '0;
      hard_cls <= 1'b0;
    end else begin
      take_stb <= do_take;
      if (do_take) begin
        take_idx <= sel_idx;
        take_lvl <= sel_lvl;
        hard_cls <= (int'(sel_idx) >= HARD_IDX_MIN);
      end
    end
  end

  // ---------------- effective priority level ----------------
  always_ff @(posedge clk) begin
    if (rst)
      ipl_out <= '0;
    else if (do_take)
      ipl_out <= sel_lvl;
    else if (do_ret)
      ipl_out <= saved_top;
    else if (depth == '0)
      ipl_out <= cur_ipl;
  end

  assign in_trap = (depth != '0);

endmodule

// File: rtl/fixed_trap_arb_chk.sv
module fixed_trap_arb_chk #(
  parameter int NLVL  = 8,
  parameter int IPL_W = 4,
  localparam int IDX_W = $clog2(NLVL)
) (
  input logic             clk,
  input logic             rst,
  input logic             clr_we,
  input logic [NLVL-1:0]  clr_mask,
  input logic             take_stb,
  input logic [IDX_W-1:0] take_idx,
  input logic [IPL_W-1:0] take_lvl,
  input logic             hard_cls,
  input logic [IPL_W-1:0] ipl_out,
  input logic             in_trap,
  input logic [NLVL-1:0]  pend_flags
);

  logic            past_ok;
  logic [NLVL-1:0] clr_seen;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assign clr_seen = clr_we ? clr_mask : '0;

  // R5: the strobe never lasts two cycles
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    take_stb |=> !take_stb);

  // R4: index and level describe the same trap
  a_r4_index_level: assert property (@(posedge clk) disable iff (rst)
    take_stb |-> (take_lvl == IPL_W'(take_idx) + IPL_W'(8)));

  // R4: the dispatched trap was pending in the cycle before the strobe
  a_r4_from_pending: assert property (@(posedge clk) disable iff (rst || !past_ok)
    take_stb |-> ((($past(pend_flags) >> take_idx) & NLVL'(1)) != '0));

  // R6: class follows the level band
  a_r6_class: assert property (@(posedge clk) disable iff (rst)
    take_stb |-> (hard_cls == (take_lvl >= IPL_W'(12))));

  // R7: the effective level equals the dispatched level
  a_r7_ipl_level: assert property (@(posedge clk) disable iff (rst)
    take_stb |-> (ipl_out == take_lvl));

  // R7: bit 3 is set whenever a trap is in service
  a_r7_ipl_bit3: assert property (@(posedge clk) disable iff (rst)
    in_trap |-> ipl_out[3]);

  // R2: a set flag only drops where a clear was written
  a_r2_sticky: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (($past(pend_flags) & ~$past(clr_seen) & ~pend_flags) == '0));

endmodule

bind fixed_trap_arb fixed_trap_arb_chk #(.NLVL(NLVL), .IPL_W(IPL_W)) u_chk (.*);

// File: tb/fixed_trap_arb_test.sv
`timescale 1ns/1ps
module fixed_trap_arb_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       math_err = 0, addr_err = 0, stack_err = 0, osc_fail = 0;
  logic [3:0] cur_ipl = 4'd0;
  logic       vec_done = 0, trap_ret = 0, clr_we = 0;
  logic [7:0] clr_mask = 8'h00;
  logic       take_stb, hard_cls, in_trap;
  logic [2:0] take_idx;
  logic [3:0] take_lvl, ipl_out;
  logic [7:0] pend_flags;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  fixed_trap_arb uut (
    .clk, .rst, .math_err, .addr_err, .stack_err, .osc_fail, .cur_ipl,
    .vec_done, .trap_ret, .clr_we, .clr_mask, .take_stb, .take_idx,
    .take_lvl, .hard_cls, .ipl_out, .in_trap, .pend_flags
  );

  // source bits [15:12] = {osc, stack, addr, math}; [11:8] cur_ipl;
  // [6:4] expected index; [0] expected hard class
  localparam logic [15:0] VEC [6] = '{
    16'h1_0_3_0,   // arithmetic alone
    16'h2_7_4_1,   // address alone with level 7 set
    16'h5_3_5_1,   // stack and arithmetic together
    16'hF_5_6_1,   // all four together
    16'h3_7_4_1,   // address and arithmetic with level 7
    16'h8_2_6_1    // clock failure alone
  };

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wclr(logic [7:0] m);
    clr_we = 1; clr_mask = m;
    step();
    clr_we = 0; clr_mask = 8'h00;
  endtask

  task automatic pulse_done();
    vec_done = 1; step(); vec_done = 0;
  endtask

  task automatic pulse_ret();
    trap_ret = 1; step(); trap_ret = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) step();
    rst = 0;
    // R1 reset state
    chk("R1 pend", pend_flags, 0);
    chk("R1 strobe", take_stb, 0);
    chk("R1 in_trap", in_trap, 0);
    chk("R1 ipl", ipl_out, 0);

    // ---------------- vector table ----------------
    for (int v = 0; v < 6; v++) begin
      logic [3:0] src;
      logic [3:0] ipl;
      logic [2:0] eidx;
      src = VEC[v][15:12];
      ipl = VEC[v][11:8];
      eidx = VEC[v][6:4];
      cur_ipl = ipl;
      step();
      {osc_fail, stack_err, addr_err, math_err} = src;
      step();
      {osc_fail, stack_err, addr_err, math_err} = 4'b0;
      chk("R2 pend set", pend_flags, {1'b0, src, 3'b000});
      chk("R5 no strobe yet", take_stb, 0);
      step();
      chk("R5 strobe", take_stb, 1);
      chk("R4 idx", take_idx, eidx);
      chk("R4 lvl", take_lvl, 4'(eidx) + 4'd8);
      chk("R6 class", hard_cls, VEC[v][0]);
      chk("R7 ipl level", ipl_out, 4'(eidx) + 4'd8);
      chk("R8 in_trap", in_trap, 1);
      wclr(8'hFF);
      pulse_done();
      pulse_ret();
      chk("R8 restore", ipl_out, ipl);
      chk("R8 in_trap low", in_trap, 0);
    end

    // ---------------- R7 tracking outside traps ----------------
    cur_ipl = 4'd5;
    step();
    chk("R7 track", ipl_out, 5);

    // ---------------- nesting, hold-off and no re-dispatch ----------------
    cur_ipl = 4'd4;
    step();
    math_err = 1; addr_err = 1;
    step();
    math_err = 0; addr_err = 0;
    chk("R2 both pend", pend_flags, 8'h18);
    step();
    chk("R4 addr first", take_idx, 4);
    chk("R5 strobe addr", take_stb, 1);
    step();
    chk("R5 one cycle", take_stb, 0);
    step();
    step();
    chk("R5 held until vec_done", take_stb, 0);
    pulse_done();
    chk("R5 none at done edge", take_stb, 0);
    step();
    chk("R8 nested strobe", take_stb, 1);
    chk("R8 nested idx", take_idx, 3);
    chk("R8 nested ipl", ipl_out, 11);
    pulse_done();
    step();
    step();
    chk("R9 no re-dispatch", take_stb, 0);
    chk("R9 flags kept", pend_flags, 8'h18);
    pulse_ret();
    chk("R8 pop inner", ipl_out, 12);
    chk("R8 still in trap", in_trap, 1);
    pulse_ret();
    chk("R8 pop outer", ipl_out, 4);
    chk("R8 trap over", in_trap, 0);

    // ---------------- R3 partial write-one-to-clear ----------------
    wclr(8'h08);
    chk("R3 partial clear", pend_flags, 8'h10);
    wclr(8'h87);
    chk("R3 reserved/others", pend_flags, 8'h10);
    wclr(8'h10);
    chk("R3 cleared", pend_flags, 8'h00);
    step();
    chk("R9 cleared no strobe", take_stb, 0);

    // ---------------- R2 set beats clear, sticky ----------------
    stack_err = 1; clr_we = 1; clr_mask = 8'h20;
    step();
    stack_err = 0; clr_we = 0; clr_mask = 8'h00;
    chk("R2 set wins", pend_flags, 8'h20);
    step();
    chk("R6 stack hard", hard_cls, 1);
    repeat (5) step();
    chk("R2 sticky", pend_flags, 8'h20);
    wclr(8'h20);
    pulse_done();
    pulse_ret();
    chk("R8 final idle", in_trap, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule